// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed 32-bit two's-complement operands over several clock cycles and returns a 64-bit signed product as a high word and a low word. A caller holds the operands steady and raises `start_i` for one cycle while the block is not busy. The block then works through the multiplier one bit per clock, using radix-2 Booth recoding. It raises `done_o` for a single cycle when the full product is ready.

The datapath has three registers: a multiplicand register, one shared product register, and a single trailing bit. The low half of the product register starts out holding the multiplier and the high half starts at zero. The trailing bit sits to the right of the product register's least significant bit and starts at 0. On every iteration the block reads a pair of bits: the product LSB (the current bit) and the trailing bit (the bit to its right). Depending on that pair, it adds the multiplicand to the high half, subtracts it from the high half, or leaves the high half alone. In the same clock it shifts the high half, low half and trailing bit right by one place, copying the sign into the top. There is only one adder/subtractor. It is one bit wider than an operand, so every signed pair, including both operands at the most negative value, gives the exact product.

A small controller sequences the work through three named states:
- IDLE: waits for a start. A start loads the operands and moves to RUN.
- RUN: performs one iteration per clock. After the last iteration it moves to FINISH.
- FINISH: lasts one cycle and asserts done. A start here loads new operands and moves straight back to RUN. Without a start it returns to IDLE.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, and `hi_o` and `lo_o` are both zero.
- R2: A start accepted while not busy raises `busy_o` in the next cycle. `busy_o` then stays high for exactly 32 consecutive cycles.
- R3: `done_o` is high for exactly one cycle. That cycle begins 33 clock edges after the edge that accepted the start, counting the accepting edge. `busy_o` is low in that cycle.
- R4: In the done cycle, `{hi_o, lo_o}` equals the exact 64-bit signed product of the multiplicand and the multiplier. This includes operands of -2^31 and 2^31-1.
- R5: Bit pair (product LSB, trailing bit) = 10 subtracts the multiplicand from the high half. Pair 01 adds it. Pairs 00 and 11 only shift. The product stays exact for multipliers made of long runs of ones, of alternating bits, and of all ones.
- R6: A start raised while `busy_o` is high is ignored. The running result is unchanged, and no extra done and no extra busy period follow.
- R7: While `busy_o` is low and no start is accepted, `hi_o` and `lo_o` hold the last result.
- R8: A start raised in the done cycle is accepted. `busy_o` is high in the next cycle, and the new result is correct.
- R9: A multiplier or multiplicand of 0 gives a product of 0. A multiplicand of 1 returns the sign-extended multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to load the operands and begin a product |
| mcand_i | input | 32 | Signed multiplicand |
| mplier_i | input | 32 | Signed multiplier |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| hi_o | output | 32 | Upper word of the product |
| lo_o | output | 32 | Lower word of the product |

## Verification
The hardest case to reach from the ports is a start that arrives in the exact cycle `done_o` is high. In that cycle the controller must leave FINISH and reload the operands, while the monitor is still retiring the previous result. The stimulus waits for the done pulse at a falling edge and drives the next start in that same half-cycle. A second hard case is a start raised in the middle of a run: the stimulus changes both operands and pulses start there, then confirms that the result of the original operands arrives alone and that no further busy period follows. The extreme operand pairs that stress the guard bit of the adder are applied directly.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } mul_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit_i,
    input  logic      right_bit_i,
    output booth_op_t op_o
);

    always_comb begin
        unique case ({cur_bit_i, right_bit_i})
            2'b10:   op_o = OP_SUB;
            2'b01:   op_o = OP_ADD;
            default: op_o = OP_NONE;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mcand_i,
    input  booth_op_t    op_i,
    output logic [W:0]   sum_o
);

    logic [W:0] acc_ext;
    logic [W:0] mc_ext;
    logic [W:0] operand;
    logic       carry_in;

    always_comb begin
        acc_ext  = {acc_i[W-1], acc_i};
        mc_ext   = {mcand_i[W-1], mcand_i};
        carry_in = 1'b0;
        unique case (op_i)
            OP_ADD:  operand = mc_ext;
            OP_SUB: begin
                operand  = ~mc_ext;
                carry_in = 1'b1;
            end
            default: operand = '0;
        endcase
        sum_o = acc_ext + operand + {{W{1'b0}}, carry_in};
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int ITER_N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (ITER_N > 2) ? $clog2(ITER_N) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITER_N - 1);

    mul_state_t       state_q, state_d;
    logic [CNT_W-1:0] iter_q;
    logic             last_iter;

    assign last_iter = (iter_q == LAST_CNT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      iter_q <= '0;
        else if (load_o) iter_q <= '0;
        else if (step_o) iter_q <= iter_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RUN;
            ST_RUN:    if (last_iter) state_d = ST_FINISH;
            ST_FINISH: state_d = start_i ? ST_RUN : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_FINISH: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [OP_W-1:0] mcand_i,
    input  logic [OP_W-1:0] mplier_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [OP_W-1:0] hi_o,
    output logic [OP_W-1:0] lo_o
);

    logic [OP_W-1:0] mcand_q;
    logic [OP_W-1:0] hi_q;
    logic [OP_W-1:0] lo_q;
    logic            trail_q;
    logic            load;
    logic            step;
    booth_op_t       op;
    logic [OP_W:0]   sum;

    booth_ctrl #(.ITER_N(OP_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    booth_recode recode_i (
        .cur_bit_i   (lo_q[0]),
        .right_bit_i (trail_q),
        .op_o        (op)
    );

    booth_addsub #(.W(OP_W)) addsub_i (
        .acc_i   (hi_q),
        .mcand_i (mcand_q),
        .op_i    (op),
        .sum_o   (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            trail_q <= 1'b0;
        end else if (load) begin
            mcand_q <= mcand_i;
            hi_q    <= '0;
            lo_q    <= mplier_i;
            trail_q <= 1'b0;
        end else if (step) begin
            hi_q    <= sum[OP_W:1];
            lo_q    <= {sum[0], lo_q[OP_W-1:1]};
            trail_q <= lo_q[0];
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int OP_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [OP_W-1:0] mcand_i,
    input logic [OP_W-1:0] mplier_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [OP_W-1:0] hi_o,
    input logic [OP_W-1:0] lo_o
);

    localparam int PW = 2 * OP_W;

    logic          busy_prev_q;
    logic [15:0]   run_len_q;
    logic [PW-1:0] ref_q;
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    assign a_ext = {{OP_W{mcand_i[OP_W-1]}}, mcand_i};
    assign b_ext = {{OP_W{mplier_i[OP_W-1]}}, mplier_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_prev_q <= 1'b0;
            run_len_q   <= '0;
            ref_q       <= '0;
        end else begin
            busy_prev_q <= busy_o;
            run_len_q   <= busy_o ? run_len_q + 16'd1 : 16'd0;
            if (start_i && !busy_o) ref_q <= a_ext * b_ext;
        end
    end

    // R2: busy period lasts exactly OP_W cycles
    a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_prev_q && !busy_o) |-> (run_len_q == 16'(OP_W)));

    // R3: done only directly after a busy period, never together with busy
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_prev_q && !busy_o));

    // R3: done lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: product matches the operands captured at the accepted start
    a_r4_product: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({hi_o, lo_o} == ref_q));

    // R6: a start while busy does not cut the run short
    a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && run_len_q < 16'(OP_W - 1)) |=> busy_o);

    // R7: result held while idle without start
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));

    // R8: start in the done cycle begins a new run
    a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> busy_o);

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.OP_W(OP_W)) chk_i (.*);

// File: tb/booth_seq_mul_tb_top.sv
module booth_seq_mul_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] hi_o;
    logic [W-1:0] lo_o;

    booth_seq_mul #(.OP_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    always #4 clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          busy_cnt = 0;
    bit          prev_done = 1'b0;
    bit          finished = 1'b0;
    logic [63:0] last_res = '0;
    logic [63:0] exp_q[$];
    int          startc_q[$];
    string       tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sa;
        logic signed [63:0] sb;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        return sa * sb;
    endfunction

    // driver: launches one product and records its expectation
    task automatic launch(input logic [31:0] a, input logic [31:0] b, input string tag);
        mcand_i  = a;
        mplier_i = b;
        start_i  = 1'b1;
        exp_q.push_back(ref_mul(a, b));
        startc_q.push_back(cyc);
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    endtask

    task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input string tag);
        while (busy_o) @(negedge clk);
        launch(a, b, tag);
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: retires expected items as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done)
                chk(1'b0, "R3 done longer than one cycle", 64'd1, 64'd0);
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 64'd1, 64'd0);
                end else begin
                    logic [63:0] e;
                    int          sc;
                    string       t;
                    e  = exp_q.pop_front();
                    sc = startc_q.pop_front();
                    t  = tag_q.pop_front();
                    chk({hi_o, lo_o} == e, t, {hi_o, lo_o}, e);
                    chk(cyc == sc + 33, "R3 done latency", 64'(cyc - sc), 64'd33);
                    chk(busy_cnt == 32, "R2 busy length", 64'(busy_cnt), 64'd32);
                    chk(busy_o == 1'b0, "R3 busy low at done", 64'(busy_o), 64'd0);
                    last_res = {hi_o, lo_o};
                end
                busy_cnt = 0;
            end else if (busy_o) begin
                busy_cnt++;
            end
            prev_done = done_o;
        end
    end

    initial begin
        logic [31:0] x;
        logic [31:0] y;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy reset", 64'(busy_o), 64'd0);
        chk(done_o == 1'b0, "R1 done reset", 64'(done_o), 64'd0);
        chk(hi_o == '0, "R1 hi reset", 64'(hi_o), 64'd0);
        chk(lo_o == '0, "R1 lo reset", 64'(lo_o), 64'd0);

        run_mul(32'd2, 32'd7, "R4 2x7");                 wait_done();
        run_mul(32'd2, -32'sd3, "R4 2x-3");              wait_done();
        run_mul(32'h8000_0000, 32'h8000_0000, "R4 minneg^2"); wait_done();
        run_mul(32'h8000_0000, 32'h7FFF_FFFF, "R4 minneg*maxpos"); wait_done();
        run_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 maxpos^2"); wait_done();
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 all ones"); wait_done();
        run_mul(32'h5555_5555, 32'hAAAA_AAAA, "R5 alternating"); wait_done();
        run_mul(32'h1234_5678, 32'h0FFF_FFF0, "R5 long run"); wait_done();
        run_mul(32'h8765_4321, 32'h8000_0001, "R5 sign run"); wait_done();
        run_mul(32'h0000_0000, 32'h1234_5678, "R9 zero mcand"); wait_done();
        run_mul(32'hDEAD_BEEF, 32'h0000_0000, "R9 zero mplier"); wait_done();
        run_mul(32'h0000_0001, 32'hDEAD_BEEF, "R9 one"); wait_done();

        // R7: result held while idle
        repeat (5) @(negedge clk);
        chk({hi_o, lo_o} == last_res, "R7 hold", {hi_o, lo_o}, last_res);

        // R6: start during a run is ignored
        run_mul(32'h0000_1234, 32'hFFFF_0003, "R6 original result");
        repeat (10) @(negedge clk);
        mcand_i  = 32'h7777_7777;
        mplier_i = 32'h3333_3333;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R6 no extra run", 64'(busy_o), 64'd0);

        // R8: start in the done cycle
        run_mul(32'h0000_0FFF, 32'h0000_1001, "R8 first");
        while (!done_o) @(negedge clk);
        launch(32'hFFFF_FF00, 32'h0001_0000, "R8 second");
        wait_done();

        // pseudo-random operands
        x = 32'h1357_9BDF;
        y = 32'h2468_ACE0;
        for (int i = 0; i < 8; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
            run_mul(x, y, "R4 random");
            wait_done();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule